// File: doc/BRIEF.md
# Packed Alternating Multiply-Add/Subtract Operand Router

This block prepares work for a bank of per-lane fused multiply-add units that evaluate a packed double-precision product followed by an alternating add or subtract. A decoded opcode byte picks one of three operand forms. Each form fixes which of the three 256-bit source vectors feeds the two multiplicand ports of each 64-bit lane and which feeds the addend. The sources are the destination register (which is also the first source), the second source taken from the prefix register selector, and the third source taken from the r/m field. Every lane also receives a negate flag for its addend. Even lanes subtract the addend from the product and odd lanes add it.

A request is taken in on a valid/ready handshake and held in registers while the lanes are issued. The block then gathers the per-lane results as the arithmetic units return them. Results may come back in any order and on different cycles. Once every active lane has reported, the block presents the 256-bit write-back value for one cycle. With the 128-bit vector length only the two low lanes are active, and the upper half of the write-back value is zero. The block also tells the units to round the exact product-plus-addend once, using the current rounding control. An opcode byte outside the three forms is swallowed and nothing is issued.

Top module: `fmas_router`

## Requirements
- R1: With opcode byte 0x96, each lane's multiplicand A is the destination lane, multiplicand B is the third-source lane and the addend is the second-source lane.
- R2: With opcode byte 0xA6, multiplicand A is the second-source lane, multiplicand B is the destination lane and the addend is the third-source lane.
- R3: With opcode byte 0xB6, multiplicand A is the second-source lane, multiplicand B is the third-source lane and the addend is the destination lane.
- R4: While lanes are issued, `lane_neg` bit i is 1 for even lane i and 0 for odd lane i (value 4'b0101 for four lanes, bit 0 = lane 0), in every form.
- R5: With `in_wide` = 0, `lane_en` is 4'b0011. Results offered on lanes 2 and 3 are ignored, and write-back bits 255:128 are zero.
- R6: With `in_wide` = 1, `lane_en` is 4'b1111, and each 64-bit lane i of the write-back holds the result returned on lane i.
- R7: A request with any other opcode byte is accepted but issues nothing. `issue_valid` and `lane_en` stay 0, `in_ready` stays 1 and no write-back is produced.
- R8: `in_ready` is 1 only while idle. A request is taken when `in_valid` and `in_ready` are both 1, `issue_valid` rises on the following cycle, and the issued operands stay stable until completion.
- R9: `wb_valid` pulses for exactly one cycle, in the cycle after the edge at which the last active lane result is returned. A repeated or early result on a lane that has already reported is ignored.
- R10: `single_round` is 1 whenever lanes are issued, telling the units to round the exact sum once with the current rounding control.
- R11: After reset, `in_ready` = 1 and `issue_valid`, `lane_en` and `wb_valid` are 0. A reset in the middle of an operation abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_opcode | input | 8 | Decoded opcode byte selecting the operand form |
| in_wide | input | 1 | 1 = 256-bit vector length, 0 = 128-bit |
| in_dst | input | 256 | Destination / first source vector |
| in_src2 | input | 256 | Second source vector (prefix register selector) |
| in_src3 | input | 256 | Third source vector (r/m register or memory) |
| issue_valid | output | 1 | Lane operands are valid |
| lane_en | output | 4 | Per-lane issue enable |
| lane_mul_a | output | 256 | Multiplicand A, 64 bits per lane |
| lane_mul_b | output | 256 | Multiplicand B, 64 bits per lane |
| lane_addend | output | 256 | Addend, 64 bits per lane |
| lane_neg | output | 4 | Per-lane addend negate flag |
| single_round | output | 1 | Round the exact sum once with the current rounding control |
| res_valid | input | 4 | Per-lane result strobe from the arithmetic units |
| res_data | input | 256 | Per-lane results, 64 bits per lane |
| wb_valid | output | 1 | Write-back value valid (one-cycle pulse) |
| wb_data | output | 256 | Assembled write-back vector |

## Verification
Every source lane carries a distinct tag that names its vector and its lane. Because of this, a routing check on each of the three forms shows which source reached each multiplicand and addend port, and shows any swap between lanes. Each form is run at both vector lengths. Results come back either all on one edge or one lane at a time in reverse order, with junk offered on the inactive lanes. This separates correct completion timing from early or late write-back, and separates correct upper-half zeroing from leakage of the ignored lanes. Directed cases cover illegal opcodes, a second request held off while busy, and a reset that abandons an issued operation.

// File: rtl/fmas_pkg.sv
package fmas_pkg;

    localparam logic [7:0] OPC_FORM132 = 8'h96;
    localparam logic [7:0] OPC_FORM213 = 8'hA6;
    localparam logic [7:0] OPC_FORM231 = 8'hB6;

    // Operand-form selection carried from decode to the lane routers
    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_132  = 2'd1,
        FORM_213  = 2'd2,
        FORM_231  = 2'd3
    } form_e;

    // Control captured with an accepted request
    typedef struct packed {
        form_e form;
        logic  wide;
    } op_ctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    function automatic form_e decode_form(input logic [7:0] opc);
        form_e f;
        case (opc)
            OPC_FORM132: f = FORM_132;
            OPC_FORM213: f = FORM_213;
            OPC_FORM231: f = FORM_231;
            default:     f = FORM_NONE;
        endcase
        return f;
    endfunction

    // Even lanes subtract the addend, odd lanes add it
    function automatic logic lane_subtracts(input int unsigned idx);
        return (idx % 2) == 0;
    endfunction

endpackage

// File: rtl/fmas_decode.sv
module fmas_decode
    import fmas_pkg::*;
#(
    parameter int unsigned OPC_W = 8
) (
    input  logic [OPC_W-1:0] opcode,
    output form_e            form,
    output logic             legal
);

    always_comb begin
        form  = decode_form(opcode[7:0]);
        legal = (form != FORM_NONE);
    end

endmodule

// File: rtl/fmas_lane_route.sv
module fmas_lane_route
    import fmas_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 64,
    localparam int unsigned VEC_W = LANES * LANE_W
) (
    input  form_e             form,
    input  logic [VEC_W-1:0]  dst,
    input  logic [VEC_W-1:0]  src2,
    input  logic [VEC_W-1:0]  src3,
    output logic [VEC_W-1:0]  mul_a,
    output logic [VEC_W-1:0]  mul_b,
    output logic [VEC_W-1:0]  addend,
    output logic [LANES-1:0]  neg
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] d_l, s2_l, s3_l;
        assign d_l  = dst [g*LANE_W +: LANE_W];
        assign s2_l = src2[g*LANE_W +: LANE_W];
        assign s3_l = src3[g*LANE_W +: LANE_W];

        always_comb begin
            case (form)
                FORM_132: begin
                    mul_a [g*LANE_W +: LANE_W] = d_l;
                    mul_b [g*LANE_W +: LANE_W] = s3_l;
                    addend[g*LANE_W +: LANE_W] = s2_l;
                end
                FORM_213: begin
                    mul_a [g*LANE_W +: LANE_W] = s2_l;
                    mul_b [g*LANE_W +: LANE_W] = d_l;
                    addend[g*LANE_W +: LANE_W] = s3_l;
                end
                FORM_231: begin
                    mul_a [g*LANE_W +: LANE_W] = s2_l;
                    mul_b [g*LANE_W +: LANE_W] = s3_l;
                    addend[g*LANE_W +: LANE_W] = d_l;
                end
                default: begin
                    mul_a [g*LANE_W +: LANE_W] = '0;
                    mul_b [g*LANE_W +: LANE_W] = '0;
                    addend[g*LANE_W +: LANE_W] = '0;
                end
            endcase
        end

        assign neg[g] = lane_subtracts(g);
    end

endmodule

// File: rtl/fmas_result_gather.sv
module fmas_result_gather
    import fmas_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 64,
    localparam int unsigned VEC_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              busy,
    input  logic [LANES-1:0]  act_mask,
    input  logic [LANES-1:0]  res_valid,
    input  logic [VEC_W-1:0]  res_data,
    output logic              finish,
    output logic              wb_valid,
    output logic [VEC_W-1:0]  wb_data
);

    logic [LANES-1:0] done_q;
    logic [LANES-1:0] take;
    logic [VEC_W-1:0] hold_q;
    logic [VEC_W-1:0] merged;

    always_comb begin
        take   = busy ? (act_mask & res_valid & ~done_q) : '0;
        finish = busy && (&((done_q | take) | ~act_mask));
        for (int i = 0; i < LANES; i++) begin
            if (!act_mask[i])
                merged[i*LANE_W +: LANE_W] = '0;
            else if (take[i])
                merged[i*LANE_W +: LANE_W] = res_data[i*LANE_W +: LANE_W];
            else
                merged[i*LANE_W +: LANE_W] = hold_q[i*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= '0;
            hold_q   <= '0;
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= finish;
            if (start) begin
                done_q <= '0;
            end else begin
                for (int i = 0; i < LANES; i++) begin
                    if (take[i]) begin
                        done_q[i] <= 1'b1;
                        hold_q[i*LANE_W +: LANE_W] <= res_data[i*LANE_W +: LANE_W];
                    end
                end
            end
            if (finish)
                wb_data <= merged;
        end
    end

    p_wb_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !wb_valid);

    p_finish_needs_busy_r9: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(busy));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        p_inactive_zero_r5: assert property (@(posedge clk) disable iff (rst)
            (wb_valid && !act_mask[g]) |-> (wb_data[g*LANE_W +: LANE_W] == '0));
    end

endmodule

// File: rtl/fmas_router.sv
module fmas_router
    import fmas_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 64,
    parameter int unsigned OPC_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [OPC_W-1:0]         in_opcode,
    input  logic                     in_wide,
    input  logic [LANES*LANE_W-1:0]  in_dst,
    input  logic [LANES*LANE_W-1:0]  in_src2,
    input  logic [LANES*LANE_W-1:0]  in_src3,
    output logic                     issue_valid,
    output logic [LANES-1:0]         lane_en,
    output logic [LANES*LANE_W-1:0]  lane_mul_a,
    output logic [LANES*LANE_W-1:0]  lane_mul_b,
    output logic [LANES*LANE_W-1:0]  lane_addend,
    output logic [LANES-1:0]         lane_neg,
    output logic                     single_round,
    input  logic [LANES-1:0]         res_valid,
    input  logic [LANES*LANE_W-1:0]  res_data,
    output logic                     wb_valid,
    output logic [LANES*LANE_W-1:0]  wb_data
);

    localparam int unsigned VEC_W = LANES * LANE_W;
    localparam int unsigned HALF  = LANES / 2;
    localparam logic [LANES-1:0] MASK_HALF = LANES'((1 << HALF) - 1);

    state_e           state_q;
    op_ctl_t          ctl_q;
    logic [VEC_W-1:0] dst_q, src2_q, src3_q;
    form_e            in_form;
    logic             in_legal;
    logic             accept;
    logic             finish;
    logic [LANES-1:0] act_mask;
    logic [LANES-1:0] neg_all;

    fmas_decode #(.OPC_W(OPC_W)) u_decode (
        .opcode (in_opcode),
        .form   (in_form),
        .legal  (in_legal)
    );

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '{form: FORM_NONE, wide: 1'b0};
            dst_q   <= '0;
            src2_q  <= '0;
            src3_q  <= '0;
        end else if (accept) begin
            ctl_q   <= '{form: in_form, wide: in_wide};
            dst_q   <= in_dst;
            src2_q  <= in_src2;
            src3_q  <= in_src3;
            state_q <= in_legal ? ST_WAIT : ST_IDLE;
        end else if (state_q == ST_WAIT && finish) begin
            state_q <= ST_IDLE;
        end
    end

    fmas_lane_route #(.LANES(LANES), .LANE_W(LANE_W)) u_route (
        .form   (ctl_q.form),
        .dst    (dst_q),
        .src2   (src2_q),
        .src3   (src3_q),
        .mul_a  (lane_mul_a),
        .mul_b  (lane_mul_b),
        .addend (lane_addend),
        .neg    (neg_all)
    );

    assign issue_valid  = (state_q == ST_WAIT);
    assign act_mask     = ctl_q.wide ? '1 : MASK_HALF;
    assign lane_en      = issue_valid ? act_mask : '0;
    assign lane_neg     = issue_valid ? neg_all : '0;
    assign single_round = issue_valid;

    fmas_result_gather #(.LANES(LANES), .LANE_W(LANE_W)) u_gather (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .busy      (issue_valid),
        .act_mask  (act_mask),
        .res_valid (res_valid),
        .res_data  (res_data),
        .finish    (finish),
        .wb_valid  (wb_valid),
        .wb_data   (wb_data)
    );

    p_issue_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_legal) |=> issue_valid);

    p_illegal_no_issue_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_legal) |=> (!issue_valid && in_ready));

    p_busy_blocks_input_r8: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> !in_ready);

    p_operands_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && $past(issue_valid)) |->
            ($stable(lane_mul_a) && $stable(lane_mul_b) && $stable(lane_addend)));

    p_wb_after_issue_r9: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (in_ready && !issue_valid));

endmodule

// File: tb/test_fmas_router.sv
module test_fmas_router;

    localparam int LANES  = 4;
    localparam int LANE_W = 64;
    localparam int VEC_W  = LANES * LANE_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_opcode = '0;
    logic             in_wide = 1'b0;
    logic [VEC_W-1:0] in_dst = '0, in_src2 = '0, in_src3 = '0;
    logic             issue_valid;
    logic [LANES-1:0] lane_en;
    logic [VEC_W-1:0] lane_mul_a, lane_mul_b, lane_addend;
    logic [LANES-1:0] lane_neg;
    logic             single_round;
    logic [LANES-1:0] res_valid = '0;
    logic [VEC_W-1:0] res_data = '0;
    logic             wb_valid;
    logic [VEC_W-1:0] wb_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fmas_router i_fmas_router (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_wide(in_wide), .in_dst(in_dst),
        .in_src2(in_src2), .in_src3(in_src3), .issue_valid(issue_valid),
        .lane_en(lane_en), .lane_mul_a(lane_mul_a), .lane_mul_b(lane_mul_b),
        .lane_addend(lane_addend), .lane_neg(lane_neg),
        .single_round(single_round), .res_valid(res_valid),
        .res_data(res_data), .wb_valid(wb_valid), .wb_data(wb_data)
    );

    // {opcode, wide, staggered-return}
    localparam logic [9:0] VECS [6] = '{
        {8'h96, 1'b1, 1'b0},
        {8'hA6, 1'b1, 1'b1},
        {8'hB6, 1'b1, 1'b0},
        {8'h96, 1'b0, 1'b1},
        {8'hA6, 1'b0, 1'b0},
        {8'hB6, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [VEC_W-1:0] make_vec(input logic [7:0] tag, input int v);
        logic [VEC_W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i*LANE_W +: LANE_W] = {tag, 8'(v), 40'h0, 8'(i)};
        return r;
    endfunction

    task automatic drive_req(input logic [7:0] opc, input logic wide, input int v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_opcode = opc;
        in_wide   = wide;
        in_dst    = make_vec(8'hD0, v);
        in_src2   = make_vec(8'h52, v);
        in_src3   = make_vec(8'h53, v);
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic run_vector(input int v);
        logic [7:0]       opc;
        logic             wide, stag;
        logic [VEC_W-1:0] d, s2, s3, ea, eb, ec, results, exp_wb;
        logic [LANES-1:0] mask;
        string            rtag;
        {opc, wide, stag} = VECS[v];
        d  = make_vec(8'hD0, v);
        s2 = make_vec(8'h52, v);
        s3 = make_vec(8'h53, v);
        case (opc)
            8'h96:   begin ea = d;  eb = s3; ec = s2; rtag = "R1"; end
            8'hA6:   begin ea = s2; eb = d;  ec = s3; rtag = "R2"; end
            default: begin ea = s2; eb = s3; ec = d;  rtag = "R3"; end
        endcase
        mask = wide ? 4'b1111 : 4'b0011;
        for (int i = 0; i < LANES; i++) begin
            results[i*LANE_W +: LANE_W] = {8'hE5, 8'(v), 40'h0, 8'(i)};
            exp_wb[i*LANE_W +: LANE_W]  = mask[i] ? results[i*LANE_W +: LANE_W] : '0;
        end

        drive_req(opc, wide, v);
        chk(issue_valid == 1'b1 && in_ready == 1'b0, "R8 issue after accept",
            {issue_valid, in_ready}, 2'b10);
        chk(lane_en == mask, wide ? "R6 lane enables" : "R5 lane enables", lane_en, mask);
        chk(lane_mul_a == ea, {rtag, " multiplicand A"}, lane_mul_a, ea);
        chk(lane_mul_b == eb, {rtag, " multiplicand B"}, lane_mul_b, eb);
        chk(lane_addend == ec, {rtag, " addend"}, lane_addend, ec);
        chk(lane_neg == 4'b0101, "R4 negate parity", lane_neg, 4'b0101);
        chk(single_round == 1'b1, "R10 single rounding", single_round, 1'b1);

        if (!stag) begin
            @(negedge clk);
            res_valid = 4'b1111;
            res_data  = results;
            if (!wide) begin
                res_data[2*LANE_W +: LANE_W] = 64'hBAD0_BAD0_BAD0_BAD2;
                res_data[3*LANE_W +: LANE_W] = 64'hBAD0_BAD0_BAD0_BAD3;
            end
            @(negedge clk);
            res_valid = '0;
        end else begin
            for (int ln = LANES - 1; ln >= 0; ln--) begin
                @(negedge clk);
                res_valid = '0;
                res_valid[ln] = 1'b1;
                res_data  = '0;
                res_data[ln*LANE_W +: LANE_W] = mask[ln] ? results[ln*LANE_W +: LANE_W]
                                                         : 64'hBAD0_BAD0_BAD0_BAD0;
                @(negedge clk);
                res_valid = '0;
                if (ln != 0) begin
                    chk(wb_valid == 1'b0, "R9 no early write-back", wb_valid, 1'b0);
                    // resend lane 3 with a different value: must be ignored
                    if (ln == LANES - 1 && wide) begin
                        res_valid[ln] = 1'b1;
                        res_data[ln*LANE_W +: LANE_W] = 64'h0BAD;
                        @(negedge clk);
                        res_valid = '0;
                    end
                end
            end
        end
        chk(wb_valid == 1'b1, "R9 write-back after last result", wb_valid, 1'b1);
        chk(wb_data == exp_wb, wide ? "R6 write-back data" : "R5 write-back upper zero",
            wb_data, exp_wb);
        @(negedge clk);
        chk(wb_valid == 1'b0 && in_ready == 1'b1, "R9 single pulse, R8 idle again",
            {wb_valid, in_ready}, 2'b01);
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1 && issue_valid == 1'b0 && lane_en == '0 && wb_valid == 1'b0,
            "R11 reset state", {in_ready, issue_valid, lane_en, wb_valid}, 7'b1000000);
        rst = 1'b0;

        for (int v = 0; v < 6; v++) run_vector(v);

        // R7: illegal opcodes
        drive_req(8'h97, 1'b1, 9);
        chk(issue_valid == 1'b0 && lane_en == '0 && in_ready == 1'b1, "R7 illegal 0x97",
            {issue_valid, lane_en, in_ready}, 6'b000001);
        drive_req(8'h00, 1'b0, 10);
        chk(issue_valid == 1'b0 && in_ready == 1'b1, "R7 illegal 0x00",
            {issue_valid, in_ready}, 2'b01);
        res_valid = 4'b1111;
        @(negedge clk);
        res_valid = '0;
        @(negedge clk);
        chk(wb_valid == 1'b0, "R7 no write-back on illegal", wb_valid, 1'b0);

        // R8: second request held off while busy
        drive_req(8'h96, 1'b1, 11);
        @(negedge clk);
        in_valid  = 1'b1;
        in_opcode = 8'hA6;
        in_dst    = make_vec(8'hD0, 12);
        @(negedge clk);
        @(negedge clk);
        chk(in_ready == 1'b0, "R8 not ready while busy", in_ready, 1'b0);
        chk(lane_mul_a == make_vec(8'hD0, 11), "R8 operands held while busy",
            lane_mul_a, make_vec(8'hD0, 11));
        in_valid  = 1'b0;
        res_valid = 4'b1111;
        res_data  = make_vec(8'hE5, 11);
        @(negedge clk);
        res_valid = '0;
        chk(wb_valid == 1'b1 && wb_data == make_vec(8'hE5, 11), "R8 first request completes",
            wb_data, make_vec(8'hE5, 11));
        @(negedge clk);
        chk(issue_valid == 1'b0, "R8 blocked request not taken", issue_valid, 1'b0);

        // R11: reset mid-operation
        drive_req(8'hB6, 1'b1, 13);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(issue_valid == 1'b0 && in_ready == 1'b1 && wb_valid == 1'b0,
            "R11 reset abandons operation", {issue_valid, in_ready, wb_valid}, 3'b010);

        finish_sim();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

endmodule